// File: doc/BRIEF.md
# Time-Aware Gate Scheduler

This block opens and closes the transmit gates of an egress port, one gate per traffic class, by stepping through a gate control list against a free-running 64-bit nanosecond time input. Each list entry pairs a time interval with a gate mask. The list starts at a programmed start time and repeats every cycle time. The gate vector goes to the frame selection logic, which only sends from classes whose gate is open.

Two lists are kept. Configuration writes go to the administrative copy while the operational copy drives the gates. A config-change strobe validates the administrative list and arms a switch. The running list keeps control until the new list's start time, and then the new list takes over at that exact time. The start time may lie in the past, in which case it is moved forward by whole cycles. If the running list's last cycle before the switch would only be a short piece, a cycle time extension lets that cycle stretch up to the switch point instead. Clearing the enable input stops scheduling and opens every gate.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and at any time no list is operational, `gate_o` is all ones and `oper_active` and `switch_pending` are low. `cap_max_len` reports MAX_ENTRIES (8 by default).
- R2: Entry k is written at `cfg_addr` = {1, k[2:0], f}, where f=0 is the 32-bit interval in ns and f=1 is the gate mask. Mask bit i opens class i. Entries run in index order from the start of each cycle, and an entry with a zero interval is never seen at the output.
- R3: A config change is rejected if the entry count exceeds `cap_max_len` or if the cycle time is zero. A rejected change arms no switch and leaves the gates and status as they were.
- R4: Scalar codes at `cfg_addr` = {00, c}: c=0 is the low half of the start time, c=1 the high half, c=2 the cycle time, c=3 the cycle time extension, and c=4 the entry count. A start time of zero means the list starts at the time value seen with the config change.
- R5: A nonzero start time earlier than the current time is moved to the first value start + N×cycle_time that is not earlier than the current time.
- R6: While `gate_en` is low, the block leaves no list active and no switch pending, `gate_o` is all ones, and config changes are ignored.
- R7: After an accepted change, `switch_pending` stays high and the old list keeps running until the time reaches the new start. At that point the new list takes over with its cycle beginning at that start, even if this falls in the middle of an old cycle.
- R8: Suppose a cycle boundary of the running list falls before the pending start, and the gap from that boundary to the start is less than the running list's extension. Then no new cycle begins at that boundary: the current cycle is stretched to the start, and it holds its last entry's mask past the cycle time.
- R9: The operational list repeats every cycle time, and `oper_active` stays high while `gate_en` is high.
- R10: If the intervals add up to more than the cycle time, the list is cut at the cycle boundary. If they add up to less, the last entry's mask is held until the cycle ends.
- R11: An operational list with zero entries keeps all gates open.
- R12: Configuration writes made while a switch is pending are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | 64 | Current time in nanoseconds |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W+2 (5) | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_change | input | 1 | Validate the administrative list and arm a switch |
| gate_en | input | 1 | Global gating enable |
| gate_o | output | NUM_TC (8) | Gate vector, bit i opens class i |
| oper_active | output | 1 | An operational list is driving the gates |
| switch_pending | output | 1 | An accepted list waits for its start time |
| cap_max_len | output | 16 | Maximum supported entry count |

## Verification
The bench goes after a switch that lands in the middle of an old cycle. A design that waits for the next boundary, or that restarts the old list, would show the wrong masks for part of that cycle. It runs a list whose intervals add up to more than the cycle time, plus a zero-interval entry; a design that does not cut at the boundary or that spends a cycle on the empty entry would leak masks across the boundary. The extension case checks that the short final cycle is folded into the previous one, which shows up as the held last mask in place of a restart. The bench also tries a start time lying in the past (a wrong alignment puts the cycle phase off), rejected counts, and writes made during a pending switch (a design that takes them would corrupt the incoming list).

// File: rtl/tas_pkg.sv
package tas_pkg;

  // First start >= now on the grid base + N*cycle; a base already ahead is kept.
  function automatic logic [63:0] align_start(input logic [63:0] base,
                                              input logic [63:0] now,
                                              input logic [31:0] cycle);
    logic [63:0] n;
    if (base >= now) return base;
    n = (now - base + 64'(cycle) - 64'd1) / 64'(cycle);
    return base + n * 64'(cycle);
  endfunction

  // Does the gap from a boundary to a pending start fit in the extension window?
  function automatic logic within_ext(input logic [63:0] boundary,
                                      input logic [63:0] start,
                                      input logic [31:0] ext);
    return (start > boundary) && ((start - boundary) < 64'(ext));
  endfunction

endpackage

// File: rtl/tas_cfg_bank.sv
module tas_cfg_bank #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int AW          = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   we,
  input  logic [AW-1:0]                          addr,
  input  logic [31:0]                            wdata,
  input  logic                                   wr_bank,
  input  logic                                   lock,
  input  logic                                   rd_bank,
  output logic [63:0]                            base_raw,
  output logic [1:0][31:0]                       ct_q,
  output logic [1:0][31:0]                       ext_q,
  output logic [1:0][15:0]                       cnt_q,
  output logic [MAX_ENTRIES-1:0][31:0]           rd_intv,
  output logic [MAX_ENTRIES-1:0][NUM_TC-1:0]     rd_mask
);
  logic [1:0][MAX_ENTRIES-1:0][31:0]       intv_q;
  logic [1:0][MAX_ENTRIES-1:0][NUM_TC-1:0] mask_q;
  logic                                    entry_area;
  logic [IDX_W-1:0]                        idx;

  assign entry_area = addr[AW-1];
  assign idx        = addr[IDX_W:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intv_q   <= '0;
      mask_q   <= '0;
      ct_q     <= '0;
      ext_q    <= '0;
      cnt_q    <= '0;
      base_raw <= '0;
    end else if (we && !lock) begin
      if (entry_area) begin
        if (addr[0]) mask_q[wr_bank][idx] <= wdata[NUM_TC-1:0];
        else         intv_q[wr_bank][idx] <= wdata;
      end else begin
        case (addr[2:0])
          3'd0:    base_raw[31:0]  <= wdata;
          3'd1:    base_raw[63:32] <= wdata;
          3'd2:    ct_q[wr_bank]   <= wdata;
          3'd3:    ext_q[wr_bank]  <= wdata;
          3'd4:    cnt_q[wr_bank]  <= wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  assign rd_intv = intv_q[rd_bank];
  assign rd_mask = mask_q[rd_bank];

endmodule

// File: rtl/tas_gate_lookup.sv
module tas_gate_lookup #(
  parameter int NUM_TC      = 8,
  parameter int MAX_ENTRIES = 8
) (
  input  logic [63:0]                        offset,
  input  logic [31:0]                        cyc_len,
  input  logic [15:0]                        cnt,
  input  logic [MAX_ENTRIES-1:0][31:0]       intv,
  input  logic [MAX_ENTRIES-1:0][NUM_TC-1:0] mask,
  output logic [NUM_TC-1:0]                  gate
);
  logic [63:0]       acc;
  logic              hit;
  logic [NUM_TC-1:0] res;
  logic [NUM_TC-1:0] last;

  always_comb begin
    acc  = '0;
    hit  = 1'b0;
    res  = '1;
    last = '1;
    for (int i = 0; i < MAX_ENTRIES; i++) begin
      if (i < int'(cnt)) begin
        if (!hit && (offset < acc + 64'(intv[i]))) begin
          res = mask[i];
          hit = 1'b1;
        end
        acc  = acc + 64'(intv[i]);
        last = mask[i];
      end
    end
    if (cnt == 16'd0)                           gate = '1;
    else if (offset >= 64'(cyc_len) || !hit)    gate = last;
    else                                        gate = res;
  end

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter  int NUM_TC      = 8,
  parameter  int MAX_ENTRIES = 8,
  localparam int IDX_W       = $clog2(MAX_ENTRIES),
  localparam int AW          = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       time_ns,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_change,
  input  logic              gate_en,
  output logic [NUM_TC-1:0] gate_o,
  output logic              oper_active,
  output logic              switch_pending,
  output logic [15:0]       cap_max_len
);
  import tas_pkg::*;

  logic        oper_sel;
  logic [63:0] cyc_start;
  logic [63:0] pend_start;
  logic        admin_bank;
  logic        rd_bank;

  logic [63:0]                        base_raw;
  logic [1:0][31:0]                   ct_q;
  logic [1:0][31:0]                   ext_q;
  logic [1:0][15:0]                   cnt_q;
  logic [MAX_ENTRIES-1:0][31:0]       rd_intv;
  logic [MAX_ENTRIES-1:0][NUM_TC-1:0] rd_mask;
  logic [NUM_TC-1:0]                  lk_gate;

  // named internal events, brought out for the checker
  logic        sw_now;
  logic        ext_hold;
  logic        wrap_now;
  logic        cfg_ok;
  logic        accept;
  logic        cfg_reject;
  logic [63:0] boundary;
  logic [63:0] nxt_start;
  logic [63:0] base_eff;

  assign cap_max_len = 16'(MAX_ENTRIES);
  assign admin_bank  = ~oper_sel;

  assign boundary  = cyc_start + 64'(ct_q[oper_sel]);
  assign sw_now    = switch_pending && (time_ns >= pend_start);
  assign ext_hold  = switch_pending && within_ext(boundary, pend_start, ext_q[oper_sel]);
  assign wrap_now  = oper_active && !sw_now && !ext_hold && (time_ns >= boundary);
  assign nxt_start = sw_now ? pend_start : (wrap_now ? boundary : cyc_start);
  assign rd_bank   = sw_now ? admin_bank : oper_sel;

  assign cfg_ok     = (cnt_q[admin_bank] <= 16'(MAX_ENTRIES)) && (ct_q[admin_bank] != 32'd0);
  assign accept     = gate_en && cfg_change && !switch_pending && cfg_ok;
  assign cfg_reject = gate_en && cfg_change && !switch_pending && !cfg_ok;
  assign base_eff   = (base_raw == 64'd0) ? time_ns : base_raw;

  tas_cfg_bank #(
    .NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .AW(AW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .wr_bank(admin_bank), .lock(switch_pending), .rd_bank(rd_bank),
    .base_raw(base_raw), .ct_q(ct_q), .ext_q(ext_q), .cnt_q(cnt_q),
    .rd_intv(rd_intv), .rd_mask(rd_mask)
  );

  tas_gate_lookup #(
    .NUM_TC(NUM_TC), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_lookup (
    .offset(time_ns - nxt_start), .cyc_len(ct_q[rd_bank]), .cnt(cnt_q[rd_bank]),
    .intv(rd_intv), .mask(rd_mask), .gate(lk_gate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oper_sel       <= 1'b0;
      cyc_start      <= '0;
      pend_start     <= '0;
      oper_active    <= 1'b0;
      switch_pending <= 1'b0;
      gate_o         <= '1;
    end else if (!gate_en) begin
      oper_active    <= 1'b0;
      switch_pending <= 1'b0;
      gate_o         <= '1;
    end else begin
      if (sw_now) begin
        oper_sel       <= admin_bank;
        oper_active    <= 1'b1;
        switch_pending <= 1'b0;
        cyc_start      <= pend_start;
      end else if (wrap_now) begin
        cyc_start <= boundary;
      end
      if (accept) begin
        switch_pending <= 1'b1;
        pend_start     <= align_start(base_eff, time_ns, ct_q[admin_bank]);
      end
      gate_o <= (oper_active || sw_now) ? lk_gate : '1;
    end
  end

endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
  parameter int NUM_TC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic [NUM_TC-1:0] gate_o,
  input logic              oper_active,
  input logic              switch_pending,
  input logic              sw_now,
  input logic              cfg_reject
);
  a_r6_disable_opens: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (&gate_o) && !oper_active && !switch_pending);

  a_r1_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !oper_active |-> (&gate_o));

  a_r7_takeover: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en && sw_now |=> oper_active && !switch_pending);

  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject && !switch_pending |=> !switch_pending);

  a_r9_oper_persists: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en && oper_active |=> oper_active);

endmodule

bind tas_gate_sched tas_gate_sched_chk #(.NUM_TC(NUM_TC)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .gate_o(gate_o),
  .oper_active(oper_active), .switch_pending(switch_pending),
  .sw_now(sw_now), .cfg_reject(cfg_reject)
);

// File: tb/tb_tas_gate_sched.sv
module tb_tas_gate_sched;
  localparam int PERIOD = 10;
  localparam int STEP   = 4;
  localparam int NENT   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_ns = 64'd1000;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_change = 1'b0;
  logic        gate_en = 1'b0;
  logic [7:0]  gate_o;
  logic        oper_active, switch_pending;
  logic [15:0] cap_max_len;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  string cur_req = "R1";

  tas_gate_sched dut (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_change(cfg_change), .gate_en(gate_en), .gate_o(gate_o),
    .oper_active(oper_active), .switch_pending(switch_pending), .cap_max_len(cap_max_len)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) time_ns <= time_ns + 64'(STEP);

  // ---------------- behavioural reference ----------------
  longint unsigned adm_base, adm_ct, adm_ext, adm_cnt;
  longint unsigned opr_ct, opr_ext, opr_cnt;
  longint unsigned adm_int[NENT], opr_int[NENT];
  bit [7:0]        adm_msk[NENT], opr_msk[NENT];
  longint unsigned m_cyc, m_pstart;
  bit              m_active, m_pend;
  bit [7:0]        m_gate;

  function automatic bit [7:0] ref_gate(longint unsigned off);
    longint unsigned edge_t = 0;
    if (opr_cnt == 0) return 8'hFF;
    if (off >= opr_ct) return opr_msk[opr_cnt-1];
    for (int k = 0; k < opr_cnt; k++) begin
      edge_t += opr_int[k];
      if (off < edge_t) return opr_msk[k];
    end
    return opr_msk[opr_cnt-1];
  endfunction

  always @(posedge clk) begin
    longint unsigned t, bnd, st;
    bit p0, sw, hold;
    t = time_ns;
    if (!rst_n) begin
      adm_base = 0; adm_ct = 0; adm_ext = 0; adm_cnt = 0;
      opr_ct = 0; opr_ext = 0; opr_cnt = 0;
      for (int k = 0; k < NENT; k++) begin
        adm_int[k] = 0; adm_msk[k] = 0; opr_int[k] = 0; opr_msk[k] = 0;
      end
      m_cyc = 0; m_pstart = 0; m_active = 0; m_pend = 0; m_gate = 8'hFF;
    end else begin
      p0 = m_pend;
      if (!gate_en) begin
        m_active = 0; m_pend = 0; m_gate = 8'hFF;
      end else begin
        bnd  = m_cyc + opr_ct;
        sw   = m_pend && t >= m_pstart;
        hold = m_pend && m_pstart > bnd && (m_pstart - bnd) < opr_ext;
        if (sw) begin
          opr_ct = adm_ct; opr_ext = adm_ext; opr_cnt = adm_cnt;
          opr_int = adm_int; opr_msk = adm_msk;
          m_cyc = m_pstart; m_active = 1; m_pend = 0;
        end else if (m_active && t >= bnd && !hold) begin
          m_cyc = bnd;
        end
        m_gate = m_active ? ref_gate(t - m_cyc) : 8'hFF;
        if (cfg_change && !p0 && adm_cnt <= NENT && adm_ct != 0) begin
          st = (adm_base == 0) ? t : adm_base;
          while (st < t) st += adm_ct;
          m_pend = 1; m_pstart = st;
        end
      end
      if (cfg_we && !p0) begin
        if (cfg_addr[4]) begin
          if (cfg_addr[0]) adm_msk[cfg_addr[3:1]] = cfg_wdata[7:0];
          else             adm_int[cfg_addr[3:1]] = cfg_wdata;
        end else begin
          case (cfg_addr[2:0])
            3'd0: adm_base[31:0]  = cfg_wdata;
            3'd1: adm_base[63:32] = cfg_wdata;
            3'd2: adm_ct  = cfg_wdata;
            3'd3: adm_ext = cfg_wdata;
            3'd4: adm_cnt = cfg_wdata[15:0];
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (gate_o !== m_gate || oper_active !== m_active || switch_pending !== m_pend) begin
        misses++;
        $display("FAIL %s t=%0d actual gate=%h act=%b pend=%b expected gate=%h act=%b pend=%b",
                 cur_req, time_ns, gate_o, oper_active, switch_pending, m_gate, m_active, m_pend);
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_change();
    cfg_change = 1'b1;
    @(negedge clk);
    cfg_change = 1'b0;
  endtask

  task automatic load(longint unsigned base, int unsigned ct, int unsigned ext, int unsigned n,
                      int unsigned iv[NENT], bit [7:0] mk[NENT]);
    wr(5'b00000, base[31:0]);
    wr(5'b00001, base[63:32]);
    wr(5'b00010, ct);
    wr(5'b00011, ext);
    wr(5'b00100, n);
    for (int k = 0; k < NENT && k < int'(n); k++) begin
      wr({1'b1, 3'(k), 1'b0}, iv[k]);
      wr({1'b1, 3'(k), 1'b1}, 32'(mk[k]));
    end
    pulse_change();
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_switch();
    for (int k = 0; k < 3000; k++) begin
      if (!switch_pending) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    misses++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int unsigned iv[NENT];
    bit [7:0]    mk[NENT];
    repeat (3) @(negedge clk);
    check("R1 gate", 64'(gate_o), 64'hFF);
    check("R1 cap", 64'(cap_max_len), 64'd8);
    rst_n = 1'b1;
    run(2);
    check("R1 idle", {62'd0, oper_active, switch_pending}, 64'd0);
    gate_en = 1'b1;

    // list A: zero start, short sum (last mask held), repeats
    cur_req = "R4 R2 R9 R10";
    iv = '{40, 60, 50, 0, 0, 0, 0, 0}; mk = '{8'h01, 8'h02, 8'h04, 0, 0, 0, 0, 0};
    load(0, 200, 0, 3, iv, mk);
    wait_switch();
    check("R4 zero base starts now", 64'(oper_active), 64'd1);
    run(150);

    // rejections
    cur_req = "R3";
    load(0, 200, 0, 9, iv, mk);
    run(2);
    check("R3 count too big", 64'(switch_pending), 64'd0);
    load(0, 0, 0, 2, iv, mk);
    run(2);
    check("R3 zero cycle", 64'(switch_pending), 64'd0);
    run(20);

    // list B: mid-cycle switch, overlong sum, zero interval entry
    cur_req = "R7 R12 R2 R10";
    iv = '{30, 0, 100, 50, 0, 0, 0, 0}; mk = '{8'h10, 8'h20, 8'h40, 8'h80, 0, 0, 0, 0};
    load(m_cyc + 277, 120, 40, 4, iv, mk);
    check("R7 pending", 64'(switch_pending), 64'd1);
    wr(5'b10001, 32'h0000_00AA);
    wait_switch();
    check("R7 took over", 64'(oper_active), 64'd1);
    run(120);

    // list C: arrival inside extension window of B
    cur_req = "R8";
    iv = '{25, 25, 0, 0, 0, 0, 0, 0}; mk = '{8'h03, 8'h0C, 0, 0, 0, 0, 0, 0};
    load(m_cyc + 260, 100, 0, 2, iv, mk);
    wait_switch();
    check("R8 switched", 64'(switch_pending), 64'd0);
    run(60);

    // list D: start in the past
    cur_req = "R5";
    iv = '{50, 50, 0, 0, 0, 0, 0, 0}; mk = '{8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0};
    load(1, 100, 0, 2, iv, mk);
    wait_switch();
    run(80);

    // list E: no entries
    cur_req = "R11";
    load(0, 80, 0, 0, iv, mk);
    wait_switch();
    run(40);
    check("R11 open", 64'(gate_o), 64'hFF);
    check("R11 active", 64'(oper_active), 64'd1);

    // disable
    cur_req = "R6";
    gate_en = 1'b0;
    run(5);
    check("R6 open", 64'(gate_o), 64'hFF);
    pulse_change();
    run(2);
    check("R6 change ignored", {62'd0, oper_active, switch_pending}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule